// File: doc/BRIEF.md
# Raw sector write sequencer

This block moves a stream of 16-bit trace words onto an ATA disk as raw, back-to-back sectors, with no file system in between. The disk is treated as one flat array of words: the block keeps its own 28-bit LBA counter and steps it after every sector, so the user only fills a FIFO and pulses start and stop. Every register access goes out as a request to a separate register access engine that handles PIO timing. The engine reports completion, and for reads it returns the status byte.

For each sector the block writes the task-file parameters and the write command. It then polls status until the disk reports it is ready for data. After that it writes exactly 256 data words. Before each data write it spends one cycle choosing and latching the next word. After reset the block first polls status until the disk is no longer busy. When tracing is told to stop, any partly written sector is filled with zero words. A closing sector then carries a fixed signature followed by zeros. An error flagged in status stops the block for good and raises the error output.

Top module: `raw_sector_writer`

## Requirements
- R1: After reset, busy is high and the block only reads register 7 (status). It keeps reading until a status byte has bit 7 (BSY) clear and bit 6 (DRDY) set. It then drops busy and waits for start. It makes no register writes during this phase.
- R2: Each sector begins with six writes, in this order: register 6 (device), 5 (LBA bits 23:16), 4 (LBA bits 15:8), 3 (LBA bits 7:0), 2 (sector count, value 1), then register 7 with command 0x30.
- R3: The device write carries 0xE0 OR LBA bits 27:24. The LBA starts at LBA_BASE after reset. It rises by one after every completed sector, including the signature sector, and it keeps its value across runs.
- R4: After the command, status (register 7) is read at least twice. Data starts only when a read that is at least the second one shows BSY (bit 7) clear and DRQ (bit 3) set. While BSY is set, polling goes on with no limit.
- R5: A sector holds exactly 256 writes to register 0, each taking the next FIFO word in order. A word is popped only when the FIFO is not empty, one word per data write.
- R6: A trace sector is not started while the FIFO is empty. Inside a sector, an empty FIFO stalls the block with no register access until a word arrives.
- R7: A stop pulse while busy affects only the words chosen after the cycle in which it is registered. From then on, the rest of the current sector is written as zero words.
- R8: After a stop, the next sector is the signature sector. Word i (i < SIG_WORDS) is 0x5A3C XOR {i[7:0], i[7:0]}, and the remaining words are zero. The block then drops busy.
- R9: If a status read after the command shows BSY clear and bit 0 (ERR) set, the error output rises and stays high. Busy falls, and no further register access or start is accepted until reset.
- R10: A start pulse while busy has no effect. A register request holds its address, write flag and data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a trace run (pulse) |
| stop_i | input | 1 | End the trace run (pulse) |
| busy_o | output | 1 | High during initialisation and while a run is active |
| err_o | output | 1 | Sticky disk error flag |
| fifo_empty_i | input | 1 | Trace FIFO has no word |
| fifo_word_i | input | 16 | Head word of the trace FIFO (show-ahead) |
| fifo_pop_o | output | 1 | Consume the head word |
| reg_req_o | output | 1 | Register access request |
| reg_wr_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | 3 | Task-file register address |
| reg_wdata_o | output | 16 | Write data |
| reg_ack_i | input | 1 | One-cycle completion of the request |
| reg_rdata_i | input | 8 | Status byte returned by a read |

## Verification
The tricky collision is a stop request landing in the same cycle that a FIFO word becomes available to a sector stalled on an empty FIFO. The bench provokes this by stalling a sector after 100 words, then pushing one word and pulsing stop on the same falling edge. The expected result is that this word is still written as word 101 and that words 102 to 256 are zero. The same run also checks that the signature sector follows directly at the next LBA.

// File: rtl/tracer_pkg.sv
package tracer_pkg;

   localparam logic [2:0] TF_DATA   = 3'd0;
   localparam logic [2:0] TF_COUNT  = 3'd2;
   localparam logic [2:0] TF_LBA_LO = 3'd3;
   localparam logic [2:0] TF_LBA_MD = 3'd4;
   localparam logic [2:0] TF_LBA_HI = 3'd5;
   localparam logic [2:0] TF_DEVICE = 3'd6;
   localparam logic [2:0] TF_CMDSTS = 3'd7;

   localparam logic [7:0] CMD_WRITE_ONE = 8'h30;

   localparam int ST_BSY  = 7;
   localparam int ST_DRDY = 6;
   localparam int ST_DRQ  = 3;
   localparam int ST_ERR  = 0;

   typedef enum logic [2:0] {
      PH_INIT,
      PH_READY,
      PH_ARM,
      PH_PARAM,
      PH_POLL,
      PH_WAIT,
      PH_DATA,
      PH_FAULT
   } phase_t;

endpackage

// File: rtl/lba_fields.sv
module lba_fields
   import tracer_pkg::*;
#(
   parameter int LBA_W = 28
) (
   input  logic [2:0]       step_i,
   input  logic [LBA_W-1:0] lba_i,
   output logic [2:0]       addr_o,
   output logic [15:0]      data_o
);

   logic [27:0] lba28;

   generate
      if (LBA_W > 28 || LBA_W < 8) begin : g_bad_width
         $error("lba_fields: LBA_W must lie in 8..28");
      end
      if (LBA_W == 28) begin : g_full
         assign lba28 = lba_i;
      end else begin : g_ext
         assign lba28 = {{(28-LBA_W){1'b0}}, lba_i};
      end
   endgenerate

   always_comb begin
      addr_o = TF_CMDSTS;
      data_o = '0;
      case (step_i)
         3'd0: begin addr_o = TF_DEVICE; data_o = {8'h00, 4'hE, lba28[27:24]}; end
         3'd1: begin addr_o = TF_LBA_HI; data_o = {8'h00, lba28[23:16]}; end
         3'd2: begin addr_o = TF_LBA_MD; data_o = {8'h00, lba28[15:8]}; end
         3'd3: begin addr_o = TF_LBA_LO; data_o = {8'h00, lba28[7:0]}; end
         3'd4: begin addr_o = TF_COUNT;  data_o = 16'h0001; end
         default: begin addr_o = TF_CMDSTS; data_o = {8'h00, CMD_WRITE_ONE}; end
      endcase
   end

endmodule

// File: rtl/sig_rom.sv
module sig_rom #(
   parameter int          SIG_WORDS = 4,
   parameter logic [15:0] SIG_BASE  = 16'h5A3C,
   parameter int          IDX_W     = 8
) (
   input  logic [IDX_W-1:0] idx_i,
   output logic [15:0]      word_o
);

   logic [15:0] tbl [SIG_WORDS];

   generate
      if (SIG_WORDS < 1 || SIG_WORDS > (1 << IDX_W)) begin : g_bad_len
         $error("sig_rom: SIG_WORDS out of range");
      end
      for (genvar i = 0; i < SIG_WORDS; i++) begin : g_word
         localparam logic [7:0] IB = 8'(i);
         assign tbl[i] = SIG_BASE ^ {IB, IB};
      end
   endgenerate

   always_comb begin
      word_o = '0;
      for (int k = 0; k < SIG_WORDS; k++) begin
         if (idx_i == IDX_W'(k)) word_o = tbl[k];
      end
   end

endmodule

// File: rtl/raw_sector_writer.sv
module raw_sector_writer
   import tracer_pkg::*;
#(
   parameter int          LBA_W        = 28,
   parameter int          LBA_BASE     = 0,
   parameter int          SECTOR_WORDS = 256,
   parameter int          SIG_WORDS    = 4,
   parameter logic [15:0] SIG_BASE     = 16'h5A3C
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        stop_i,
   output logic        busy_o,
   output logic        err_o,
   input  logic        fifo_empty_i,
   input  logic [15:0] fifo_word_i,
   output logic        fifo_pop_o,
   output logic        reg_req_o,
   output logic        reg_wr_o,
   output logic [2:0]  reg_addr_o,
   output logic [15:0] reg_wdata_o,
   input  logic        reg_ack_i,
   input  logic [7:0]  reg_rdata_i
);

   localparam int             CW   = $clog2(SECTOR_WORDS);
   localparam logic [CW-1:0]  LAST = CW'(SECTOR_WORDS - 1);

   generate
      if (SECTOR_WORDS != (1 << CW)) begin : g_bad_sector
         $error("raw_sector_writer: SECTOR_WORDS must be a power of two");
      end
   endgenerate

   phase_t           phase;
   logic [2:0]       step;
   logic [1:0]       polls;
   logic [CW-1:0]    wcnt;
   logic             sig_sec;
   logic             stop_req;
   logic [15:0]      wbuf;
   logic [LBA_W-1:0] lba;

   logic [2:0]  f_addr;
   logic [15:0] f_data;
   logic [15:0] rom_word;
   logic        unused_status;

   assign unused_status = ^{reg_rdata_i[5:4], reg_rdata_i[2:1]};

   lba_fields #(.LBA_W(LBA_W)) u_fields (
      .step_i (step),
      .lba_i  (lba),
      .addr_o (f_addr),
      .data_o (f_data)
   );

   sig_rom #(.SIG_WORDS(SIG_WORDS), .SIG_BASE(SIG_BASE), .IDX_W(CW)) u_rom (
      .idx_i  (wcnt),
      .word_o (rom_word)
   );

   logic active;
   assign active = (phase != PH_READY) && (phase != PH_FAULT) && (phase != PH_INIT);

   assign busy_o     = (phase != PH_READY) && (phase != PH_FAULT);
   assign err_o      = (phase == PH_FAULT);
   assign fifo_pop_o = (phase == PH_WAIT) && !sig_sec && !stop_req && !fifo_empty_i;

   always_comb begin
      reg_req_o   = 1'b0;
      reg_wr_o    = 1'b0;
      reg_addr_o  = TF_CMDSTS;
      reg_wdata_o = '0;
      case (phase)
         PH_INIT, PH_POLL: reg_req_o = 1'b1;
         PH_PARAM: begin
            reg_req_o   = 1'b1;
            reg_wr_o    = 1'b1;
            reg_addr_o  = f_addr;
            reg_wdata_o = f_data;
         end
         PH_DATA: begin
            reg_req_o   = 1'b1;
            reg_wr_o    = 1'b1;
            reg_addr_o  = TF_DATA;
            reg_wdata_o = wbuf;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_INIT;
         step     <= '0;
         polls    <= '0;
         wcnt     <= '0;
         sig_sec  <= 1'b0;
         stop_req <= 1'b0;
         wbuf     <= '0;
         lba      <= LBA_W'(LBA_BASE);
      end else begin
         if (active && stop_i) stop_req <= 1'b1;
         case (phase)
            PH_INIT: begin
               if (reg_ack_i && !reg_rdata_i[ST_BSY] && reg_rdata_i[ST_DRDY])
                  phase <= PH_READY;
            end
            PH_READY: begin
               if (start_i) begin
                  stop_req <= 1'b0;
                  phase    <= PH_ARM;
               end
            end
            PH_ARM: begin
               step <= '0;
               if (stop_req) begin
                  sig_sec  <= 1'b1;
                  stop_req <= 1'b0;
                  phase    <= PH_PARAM;
               end else if (!fifo_empty_i) begin
                  sig_sec <= 1'b0;
                  phase   <= PH_PARAM;
               end
            end
            PH_PARAM: begin
               if (reg_ack_i) begin
                  if (step == 3'd5) begin
                     polls <= '0;
                     phase <= PH_POLL;
                  end else begin
                     step <= step + 3'd1;
                  end
               end
            end
            PH_POLL: begin
               if (reg_ack_i) begin
                  if (polls != 2'd3) polls <= polls + 2'd1;
                  if (!reg_rdata_i[ST_BSY] && reg_rdata_i[ST_ERR]) begin
                     phase <= PH_FAULT;
                  end else if (polls != 2'd0 && !reg_rdata_i[ST_BSY] && reg_rdata_i[ST_DRQ]) begin
                     wcnt  <= '0;
                     phase <= PH_WAIT;
                  end
               end
            end
            PH_WAIT: begin
               if (sig_sec) begin
                  wbuf  <= rom_word;
                  phase <= PH_DATA;
               end else if (stop_req) begin
                  wbuf  <= '0;
                  phase <= PH_DATA;
               end else if (!fifo_empty_i) begin
                  wbuf  <= fifo_word_i;
                  phase <= PH_DATA;
               end
            end
            PH_DATA: begin
               if (reg_ack_i) begin
                  if (wcnt == LAST) begin
                     lba   <= lba + LBA_W'(1);
                     phase <= sig_sec ? PH_READY : PH_ARM;
                  end else begin
                     wcnt  <= wcnt + CW'(1);
                     phase <= PH_WAIT;
                  end
               end
            end
            default: phase <= PH_FAULT;
         endcase
      end
   end

   assert_pop_needs_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop_o |-> !fifo_empty_i);

   assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req_o && !reg_ack_i) |=> (reg_req_o && $stable(reg_addr_o)
                                     && $stable(reg_wr_o) && $stable(reg_wdata_o)));

   assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> (err_o && !reg_req_o && !busy_o));

   assert_lba_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA && reg_ack_i && wcnt == LAST) |=> (lba == $past(lba) + LBA_W'(1)));

   assert_two_polls_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT) |-> (polls >= 2'd2));

   assert_init_reads_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_INIT) |-> (!reg_wr_o && busy_o));

endmodule

// File: tb/raw_sector_writer_tb.sv
module raw_sector_writer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        stop_i = 1'b0;
   logic        busy_o, err_o;
   logic        fifo_empty_i;
   logic [15:0] fifo_word_i;
   logic        fifo_pop_o;
   logic        reg_req_o, reg_wr_o;
   logic [2:0]  reg_addr_o;
   logic [15:0] reg_wdata_o;
   logic        reg_ack_i;
   logic [7:0]  reg_rdata_i;

   always #10 clk = ~clk;

   raw_sector_writer u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .busy_o(busy_o), .err_o(err_o),
      .fifo_empty_i(fifo_empty_i), .fifo_word_i(fifo_word_i), .fifo_pop_o(fifo_pop_o),
      .reg_req_o(reg_req_o), .reg_wr_o(reg_wr_o), .reg_addr_o(reg_addr_o),
      .reg_wdata_o(reg_wdata_o), .reg_ack_i(reg_ack_i), .reg_rdata_i(reg_rdata_i)
   );

   int checks = 0;
   int errors = 0;

   // FIFO model
   logic [15:0] fmem [1024];
   int          f_wr = 0;
   int          f_rd;
   assign fifo_empty_i = (f_rd >= f_wr);
   assign fifo_word_i  = fmem[f_rd[9:0]];

   // register engine and disk status model
   int          lat = 0;
   int          bsy_reads = 3;
   int          err_at = -1;
   int          wc, ridx;
   logic        log_wr [4096];
   logic [2:0]  log_a  [4096];
   logic [15:0] log_d  [4096];
   int          log_n;

   function automatic logic [7:0] status_for(input int k);
      if (k == err_at) return 8'h41;
      if (k < bsy_reads) return 8'h80;
      return 8'h48;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_rd <= 0; reg_ack_i <= 1'b0; reg_rdata_i <= 8'h00;
         wc <= 0; ridx <= 0; log_n <= 0;
      end else begin
         if (fifo_pop_o) f_rd <= f_rd + 1;
         if (reg_ack_i) reg_ack_i <= 1'b0;
         else if (reg_req_o) begin
            if (wc >= lat) begin
               reg_ack_i <= 1'b1;
               wc <= 0;
               log_wr[log_n] <= reg_wr_o;
               log_a[log_n]  <= reg_addr_o;
               log_d[log_n]  <= reg_wdata_o;
               log_n <= log_n + 1;
               if (reg_wr_o) begin
                  if (reg_addr_o == 3'd7) ridx <= 0;
               end else begin
                  reg_rdata_i <= status_for(ridx);
                  ridx <= ridx + 1;
               end
            end else wc <= wc + 1;
         end
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 190000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 190000)", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input logic ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: act %0h exp %0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [15:0] w);
      fmem[f_wr[9:0]] = w;
      f_wr = f_wr + 1;
   endtask

   task automatic pulse_start();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
   endtask

   task automatic wait_log(input int n);
      for (int t = 0; t < 20000 && log_n < n; t++) @(negedge clk);
   endtask

   task automatic wait_idle();
      for (int t = 0; t < 20000 && busy_o; t++) @(negedge clk);
   endtask

   logic [15:0] exp_w [256];
   int exp_lba = 0;

   // checks six parameter writes plus the status reads; returns index of first data entry
   task automatic chk_hdr(input int at, input int lba, input int nreads, output int nxt);
      logic [2:0]  ea [6];
      logic [15:0] ed [6];
      int bad = 0;
      int rd = 0;
      int k;
      ea = '{3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd7};
      ed = '{16'h00E0 | 16'((lba >> 24) & 15), 16'((lba >> 16) & 255),
             16'((lba >> 8) & 255), 16'(lba & 255), 16'h0001, 16'h0030};
      for (int i = 0; i < 6; i++)
         if (!log_wr[at+i] || log_a[at+i] != ea[i] || log_d[at+i] != ed[i]) bad++;
      check(bad == 0, "R2/R3", "parameter writes mismatching", bad, 0);
      k = at + 6;
      while (k < log_n && !log_wr[k]) begin
         if (log_a[k] != 3'd7) bad++;
         rd++; k++;
      end
      check(rd == nreads, "R4", "status reads after command", rd, nreads);
      nxt = k;
   endtask

   task automatic chk_data(input int at, input string req);
      int bad = 0;
      int first = -1;
      for (int i = 0; i < 256; i++)
         if (!log_wr[at+i] || log_a[at+i] != 3'd0 || log_d[at+i] != exp_w[i]) begin
            if (first < 0) first = i;
            bad++;
         end
      check(bad == 0, req, "data words wrong (first bad index)", first, -1);
   endtask

   task automatic fill_sig();
      for (int i = 0; i < 256; i++)
         exp_w[i] = (i < 4) ? (16'h5A3C ^ {8'(i), 8'(i)}) : 16'h0000;
   endtask

   localparam logic [23:0] RUNS [3] = '{
      {16'h1000, 4'd0, 4'd0},
      {16'hBEEF, 4'd3, 4'd2},
      {16'h0042, 4'd1, 4'd1}
   };

   initial begin
      int base, nx, nr;
      bsy_reads = 3;
      #5;
      @(negedge clk);
      @(negedge clk);
      check(busy_o == 1'b1 && err_o == 1'b0, "R1", "busy/err during reset", {busy_o, err_o}, 2'b10);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy_o == 1'b1, "R1", "busy while initialising", busy_o, 1);
      wait_idle();
      begin
         int wr = 0;
         for (int i = 0; i < log_n; i++) if (log_wr[i]) wr++;
         check(busy_o == 1'b0 && wr == 0 && log_n == 4, "R1", "init reads/writes (reads)",
               log_n, 4);
      end

      // table of runs: one trace sector, then stop at the sector boundary
      foreach (RUNS[r]) begin
         logic [15:0] seed;
         seed      = RUNS[r][23:8];
         bsy_reads = int'(RUNS[r][7:4]);
         lat       = int'(RUNS[r][3:0]);
         nr        = (bsy_reads + 1 < 2) ? 2 : bsy_reads + 1;
         base      = log_n;
         for (int i = 0; i < 256; i++) begin
            exp_w[i] = seed + 16'(i * 3);
            push(exp_w[i]);
         end
         pulse_start();
         wait_log(base + 10);
         pulse_start(); // R10: ignored while busy
         wait_log(base + 6 + nr + 256);
         @(negedge clk) stop_i = 1'b1;
         @(negedge clk) stop_i = 1'b0;
         wait_idle();
         chk_hdr(base, exp_lba, nr, nx);
         chk_data(nx, "R5");
         exp_lba++;
         chk_hdr(nx + 256, exp_lba, nr, nx);
         fill_sig();
         chk_data(nx, "R8");
         exp_lba++;
         repeat (20) @(negedge clk);
         check(log_n == nx + 256 && !busy_o, "R10", "log length after run", log_n, nx + 256);
      end

      // stall on empty FIFO, then word and stop in the same cycle
      bsy_reads = 0; lat = 0; nr = 2;
      base = log_n;
      pulse_start();
      repeat (20) @(negedge clk);
      check(log_n == base && busy_o, "R6", "no sector opened on empty FIFO", log_n, base);
      @(negedge clk);
      for (int i = 0; i < 100; i++) push(16'h7000 + 16'(i));
      wait_log(base + 6 + nr + 100);
      repeat (40) @(negedge clk);
      check(log_n == base + 6 + nr + 100, "R6", "no access while stalled", log_n,
            base + 6 + nr + 100);
      @(negedge clk);
      push(16'h7064);
      stop_i = 1'b1;
      @(negedge clk) stop_i = 1'b0;
      wait_idle();
      for (int i = 0; i < 256; i++) exp_w[i] = (i <= 100) ? 16'h7000 + 16'(i) : 16'h0000;
      chk_hdr(base, exp_lba, nr, nx);
      chk_data(nx, "R7");
      exp_lba++;
      chk_hdr(nx + 256, exp_lba, nr, nx);
      fill_sig();
      chk_data(nx, "R8");
      exp_lba++;

      // disk error on the second status read
      err_at = 1;
      base = log_n;
      push(16'h1234);
      pulse_start();
      for (int t = 0; t < 2000 && !err_o; t++) @(negedge clk);
      check(err_o == 1'b1 && busy_o == 1'b0, "R9", "error state outputs", {err_o, busy_o}, 2'b10);
      pulse_start();
      repeat (30) @(negedge clk);
      check(log_n == base + 8 && err_o, "R9", "accesses after error", log_n, base + 8);
      check(fifo_empty_i == 1'b0, "R9", "FIFO word untouched (empty flag)", fifo_empty_i, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule